// File: doc/BRIEF.md
# PWM Idle Timeout and Output Mode Controller

This block sits between a duty-cycle measurement stage and a pair of DAC channels. For each channel it watches the PWM input level. It takes a measured code from the converter on each rising edge. It decides which code the DAC receives, whether the DAC output drives or floats, and when a new code is strobed into the DAC. A per-channel watchdog timer restarts on every rising edge. It is built from a clock prescaler and a tick counter. A measured code is only accepted when it closes an edge pair no farther apart than the timeout.

When a channel's timer runs out, the controller applies an idle action. A static mode input selects between transparent operation and sample/hold operation, and the current input level picks the action within that mode. The same mode input also fixes the state the channels take out of reset. A global active-low sleep input blanks both channels. After sleep is released, a transparent part resumes at once. A sample/hold part stays asleep until a rising edge arrives on any input, and each channel floats until it has been updated again. A reference-off flag tells the reference circuitry when it may shut down.

Top module: `pwmidle_ctrl`

## Requirements
- R1: Out of reset, in transparent mode (`hold_mode`=0) every channel drives code 0 with `dac_drive`=1. In sample/hold mode (`hold_mode`=1) every channel has `dac_drive`=0. No load strobe is issued in either mode.
- R2: A rising edge that comes no more than TIMEOUT = PRESC_LEN*TIMEOUT_TICKS cycles after the previous rising edge of the same channel loads that cycle's `meas_code` into `dac_code` on the next cycle. `dac_drive`=1 and `dac_load` is high for exactly that one cycle. A spacing of exactly TIMEOUT is still accepted.
- R3: A rising edge that opens a pair, and has no earlier rising edge within TIMEOUT cycles, changes neither `dac_code` nor `dac_load`.
- R4: If no rising edge arrives for TIMEOUT cycles, the idle action appears on the following cycle. In transparent mode, a low input gives code 0 and a high input gives code all-ones, each with one load strobe.
- R5: In transparent mode, a channel that went idle high and then falls applies the low action (code 0 with a load) TIMEOUT+1 cycles after the falling edge.
- R6: In sample/hold mode, idling low sets `dac_drive`=0 and keeps the code. Idling high keeps code and drive unchanged, with no load.
- R7: In sample/hold mode, a channel keeps `dac_drive`=0 until an accepted edge pair loads it.
- R8: The cycle after `sleep_n` is sampled low, every `dac_drive` and `dac_load` is 0 and `ref_off` is 1.
- R9: After `sleep_n` returns high, transparent mode drives again on the next cycle. Sample/hold mode floats every channel until that channel loads a code through a new accepted edge pair.
- R10: `ref_off` is 1 whenever `ext_ref` is 1, the block is asleep, or no channel drives. Otherwise it is 0.
- R11: Each channel's timing, edges and outputs are independent of the other channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hold_mode | input | 1 | Static mode: 0 transparent, 1 sample/hold |
| ext_ref | input | 1 | External reference in use |
| sleep_n | input | 1 | Global active-low power-down |
| pwm_lvl | input | NCH | Synchronised PWM level per channel |
| meas_code | input | NCH*CODE_W | Converter result per channel, valid in the rising-edge cycle |
| dac_code | output | NCH*CODE_W | Code per channel toward the DAC |
| dac_drive | output | NCH | Output enable per channel, 0 means high impedance |
| dac_load | output | NCH | One-cycle update strobe per channel |
| ref_off | output | 1 | Reference may be shut down |

## Verification
A stale or wrong timer shows up as an idle action that lands one or more cycles away from TIMEOUT+1 after the last edge. The checks sample the cycle just before and the cycle of the expected action. A wrong channel state appears at the next rising edge as a load that should not happen, or a missing one. This happens within one cycle of that edge, and the exact-TIMEOUT spacing exposes off-by-one acceptance. Sleep handling errors show as an output that drives a cycle early, or a float that lasts past the edge pair that should end it.

// File: rtl/pwmidle_pkg.sv
package pwmidle_pkg;

   typedef enum logic [1:0] {
      CH_QUIET  = 2'd0,
      CH_RUN    = 2'd1,
      CH_SETTLE = 2'd2
   } ch_state_e;

   typedef enum logic [1:0] {
      IDLE_ZERO = 2'd0,
      IDLE_FULL = 2'd1,
      IDLE_HOLD = 2'd2,
      IDLE_OFF  = 2'd3
   } idle_act_e;

   // idle action from mode and level
   function automatic idle_act_e idle_action(input logic hold, input logic lvl);
      if (!hold) return lvl ? IDLE_FULL : IDLE_ZERO;
      return lvl ? IDLE_HOLD : IDLE_OFF;
   endfunction

endpackage

// File: rtl/pwmidle_timer.sv
module pwmidle_timer #(
   parameter int unsigned PRESC_LEN     = 100000,
   parameter int unsigned TIMEOUT_TICKS = 60
) (
   input  logic clk,
   input  logic rst_n,
   input  logic restart,
   input  logic run,
   output logic expire
);
   localparam int unsigned TW = (TIMEOUT_TICKS > 1) ? $clog2(TIMEOUT_TICKS) : 1;
   localparam logic [TW-1:0] T_LAST = TW'(TIMEOUT_TICKS - 1);

   if (PRESC_LEN < 1 || TIMEOUT_TICKS < 1 || PRESC_LEN * TIMEOUT_TICKS < 2) begin : g_bad_cfg
      $error("pwmidle_timer: timeout must span at least two cycles");
   end

   logic          tick;
   logic [TW-1:0] tick_q;

   if (PRESC_LEN == 1) begin : g_nopresc
      assign tick = 1'b1;
   end else begin : g_presc
      localparam int unsigned PW = $clog2(PRESC_LEN);
      localparam logic [PW-1:0] P_LAST = PW'(PRESC_LEN - 1);
      logic [PW-1:0] pre_q;
      always_ff @(posedge clk) begin
         if (!rst_n || restart) pre_q <= '0;
         else if (run)          pre_q <= (pre_q == P_LAST) ? '0 : pre_q + PW'(1);
      end
      assign tick = (pre_q == P_LAST);
   end

   always_ff @(posedge clk) begin
      if (!rst_n || restart)  tick_q <= '0;
      else if (run && tick)   tick_q <= (tick_q == T_LAST) ? '0 : tick_q + TW'(1);
   end

   assign expire = run && tick && (tick_q == T_LAST);

   // R4
   restart_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> !expire);

endmodule

// File: rtl/pwmidle_sleep.sv
module pwmidle_sleep (
   input  logic clk,
   input  logic rst_n,
   input  logic sleep_n,
   input  logic hold_mode,
   input  logic any_rise,
   output logic asleep,
   output logic force_off
);
   logic asleep_q;

   always_ff @(posedge clk) begin
      if (!rst_n)                           asleep_q <= 1'b0;
      else if (!sleep_n)                    asleep_q <= 1'b1;
      else if (!hold_mode || any_rise)      asleep_q <= 1'b0;
   end

   assign asleep    = asleep_q;
   assign force_off = !sleep_n && hold_mode;

   // R9
   hold_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (asleep_q && sleep_n && hold_mode && !any_rise) |=> asleep_q);

endmodule

// File: rtl/pwmidle_chan.sv
module pwmidle_chan
   import pwmidle_pkg::*;
#(
   parameter int unsigned CODE_W        = 12,
   parameter int unsigned PRESC_LEN     = 100000,
   parameter int unsigned TIMEOUT_TICKS = 60
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hold_mode,
   input  logic              force_off,
   input  logic              lvl,
   input  logic [CODE_W-1:0] meas,
   output logic [CODE_W-1:0] code_o,
   output logic              en_o,
   output logic              load_o,
   output logic              rise_o
);
   ch_state_e         state_q, state_d;
   logic [CODE_W-1:0] code_q, code_d;
   logic              en_q, en_d;
   logic              load_q, load_d;
   logic              lvl_q;
   logic              rise, fall, expire;
   idle_act_e         act;

   assign rise = lvl && !lvl_q;
   assign fall = !lvl && lvl_q;

   pwmidle_timer #(
      .PRESC_LEN     (PRESC_LEN),
      .TIMEOUT_TICKS (TIMEOUT_TICKS)
   ) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (rise || (fall && state_q == CH_QUIET)),
      .run     (state_q != CH_QUIET),
      .expire  (expire)
   );

   always_comb begin
      state_d = state_q;
      code_d  = code_q;
      en_d    = en_q;
      load_d  = 1'b0;
      act     = idle_action(hold_mode, lvl);
      if (force_off) begin
         state_d = CH_QUIET;
         en_d    = 1'b0;
      end else begin
         unique case (state_q)
            CH_QUIET: begin
               if (rise)      state_d = CH_RUN;
               else if (fall) state_d = CH_SETTLE;
            end
            CH_RUN, CH_SETTLE: begin
               if (rise) begin
                  state_d = CH_RUN;
                  if (state_q == CH_RUN) begin
                     code_d = meas;
                     en_d   = 1'b1;
                     load_d = 1'b1;
                  end
               end else if (expire) begin
                  state_d = CH_QUIET;
                  unique case (act)
                     IDLE_ZERO: begin code_d = '0; en_d = 1'b1; load_d = 1'b1; end
                     IDLE_FULL: begin code_d = '1; en_d = 1'b1; load_d = 1'b1; end
                     IDLE_OFF:  en_d = 1'b0;
                     IDLE_HOLD: ;
                  endcase
               end
            end
            default: state_d = CH_QUIET;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      lvl_q <= rst_n ? lvl : 1'b0;
      if (!rst_n) begin
         state_q <= CH_QUIET;
         code_q  <= '0;
         en_q    <= !hold_mode;
         load_q  <= 1'b0;
      end else begin
         state_q <= state_d;
         code_q  <= code_d;
         en_q    <= en_d;
         load_q  <= load_d;
      end
   end

   assign code_o = code_q;
   assign en_o   = en_q;
   assign load_o = load_q;
   assign rise_o = rise;

   // R2
   code_needs_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(code_q) |-> load_q);
   // R2
   load_drives_chk: assert property (@(posedge clk) disable iff (!rst_n)
      load_q |-> en_q);
   // R4
   transparent_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !hold_mode |-> en_q);
   // R6
   hold_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (expire && hold_mode && lvl && !rise && !force_off)
      |=> ($stable(code_q) && $stable(en_q) && !load_q));

endmodule

// File: rtl/pwmidle_ctrl.sv
module pwmidle_ctrl #(
   parameter int unsigned NCH           = 2,
   parameter int unsigned CODE_W        = 12,
   parameter int unsigned PRESC_LEN     = 100000,
   parameter int unsigned TIMEOUT_TICKS = 60
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  hold_mode,
   input  logic                  ext_ref,
   input  logic                  sleep_n,
   input  logic [NCH-1:0]        pwm_lvl,
   input  logic [NCH*CODE_W-1:0] meas_code,
   output logic [NCH*CODE_W-1:0] dac_code,
   output logic [NCH-1:0]        dac_drive,
   output logic [NCH-1:0]        dac_load,
   output logic                  ref_off
);
   if (NCH < 1 || CODE_W < 1) begin : g_bad_cfg
      $error("pwmidle_ctrl: NCH and CODE_W must be positive");
   end

   logic [NCH-1:0] en_int, load_int, rise_int;
   logic           asleep, force_off;

   pwmidle_sleep u_sleep (
      .clk       (clk),
      .rst_n     (rst_n),
      .sleep_n   (sleep_n),
      .hold_mode (hold_mode),
      .any_rise  (|rise_int),
      .asleep    (asleep),
      .force_off (force_off)
   );

   for (genvar c = 0; c < NCH; c++) begin : g_ch
      pwmidle_chan #(
         .CODE_W        (CODE_W),
         .PRESC_LEN     (PRESC_LEN),
         .TIMEOUT_TICKS (TIMEOUT_TICKS)
      ) u_chan (
         .clk       (clk),
         .rst_n     (rst_n),
         .hold_mode (hold_mode),
         .force_off (force_off),
         .lvl       (pwm_lvl[c]),
         .meas      (meas_code[c*CODE_W +: CODE_W]),
         .code_o    (dac_code[c*CODE_W +: CODE_W]),
         .en_o      (en_int[c]),
         .load_o    (load_int[c]),
         .rise_o    (rise_int[c])
      );
      assign dac_drive[c] = en_int[c] && !asleep;
      assign dac_load[c]  = load_int[c] && !asleep;
   end

   assign ref_off = ext_ref || asleep || (dac_drive == '0);

   // R8
   sleep_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !sleep_n |=> (dac_drive == '0 && dac_load == '0 && ref_off));

endmodule

// File: tb/tb_pwmidle_ctrl.sv
module tb_pwmidle_ctrl;
   localparam int NCH = 2, W = 8, P = 4, T = 8;

   logic clk = 1'b0;
   logic rst_n, hold_mode, ext_ref, sleep_n;
   logic [NCH-1:0]   pwm_lvl;
   logic [NCH*W-1:0] meas_code, dac_code;
   logic [NCH-1:0]   dac_drive, dac_load;
   logic             ref_off;

   pwmidle_ctrl #(.NCH(NCH), .CODE_W(W), .PRESC_LEN(P), .TIMEOUT_TICKS(T)) dut (
      .clk(clk), .rst_n(rst_n), .hold_mode(hold_mode), .ext_ref(ext_ref),
      .sleep_n(sleep_n), .pwm_lvl(pwm_lvl), .meas_code(meas_code),
      .dac_code(dac_code), .dac_drive(dac_drive), .dac_load(dac_load),
      .ref_off(ref_off));

   always #2 clk = ~clk;

   int cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   typedef struct {
      int         due;
      int         ch;
      logic [7:0] code;
      bit         drv;
      bit         ld;
      string      tag;
   } item_t;
   item_t q[$];

   int  errors = 0, checks = 0;
   bit  done = 0, ended = 0;

   task automatic tick(int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic set_pwm(int ch, bit v, logic [7:0] code);
      pwm_lvl[ch] = v;
      meas_code[ch*W +: W] = code;
   endtask

   task automatic exp_ch(int due, int ch, logic [7:0] code, bit drv, bit ld, string tag);
      item_t it;
      it.due = due; it.ch = ch; it.code = code; it.drv = drv; it.ld = ld; it.tag = tag;
      q.push_back(it);
   endtask

   task automatic exp_ref(int due, bit v, string tag);
      item_t it;
      it.due = due; it.ch = -1; it.code = 8'h00; it.drv = v; it.ld = 1'b0; it.tag = tag;
      q.push_back(it);
   endtask

   always @(negedge clk) begin
      for (int i = q.size() - 1; i >= 0; i--) begin
         if (q[i].due <= cyc) begin
            checks++;
            if (q[i].ch < 0) begin
               if (ref_off !== q[i].drv) begin
                  errors++;
                  $display("FAIL %s cyc=%0d ref_off act=%b exp=%b", q[i].tag, cyc, ref_off, q[i].drv);
               end
            end else if (dac_code[q[i].ch*W +: W] !== q[i].code ||
                         dac_drive[q[i].ch] !== q[i].drv || dac_load[q[i].ch] !== q[i].ld) begin
               errors++;
               $display("FAIL %s cyc=%0d ch%0d act code=%h drv=%b ld=%b exp code=%h drv=%b ld=%b",
                        q[i].tag, cyc, q[i].ch, dac_code[q[i].ch*W +: W], dac_drive[q[i].ch],
                        dac_load[q[i].ch], q[i].code, q[i].drv, q[i].ld);
            end
            q.delete(i);
         end
      end
   end

   task automatic finish_up();
      if (!ended) begin
         ended = 1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog expired at cyc=%0d", cyc);
         finish_up();
      end
   end

   initial begin
      int t, s, b, k, w;
      rst_n = 0; hold_mode = 0; ext_ref = 0; sleep_n = 1;
      pwm_lvl = '0; meas_code = '0;
      tick(4);
      rst_n = 1;
      // R1 transparent reset state
      exp_ch(cyc, 0, 8'h00, 1, 0, "R1");
      exp_ch(cyc, 1, 8'h00, 1, 0, "R1");
      exp_ref(cyc, 0, "R10");
      tick(2);
      // R2 first edge only arms, second loads
      set_pwm(0, 1, 8'h40); t = cyc;
      exp_ch(t + 1, 0, 8'h00, 1, 0, "R3 lone edge");
      tick(5); set_pwm(0, 0, 8'h40);
      tick(5); set_pwm(0, 1, 8'h5A); t = cyc;
      exp_ch(t + 1, 0, 8'h5A, 1, 1, "R2");
      exp_ch(t + 2, 0, 8'h5A, 1, 0, "R2 one-cycle load");
      exp_ch(t + 1, 1, 8'h00, 1, 0, "R11");
      tick(3); set_pwm(0, 0, 8'h5A);
      tick(29); set_pwm(0, 1, 8'h33); t = cyc;   // spacing exactly TIMEOUT
      exp_ch(t + 1, 0, 8'h33, 1, 1, "R2 boundary");
      tick(3); set_pwm(0, 0, 8'h33);
      // R4 idle low in transparent
      exp_ch(t + 32, 0, 8'h33, 1, 0, "R4 before");
      exp_ch(t + 33, 0, 8'h00, 1, 1, "R4 low");
      tick(40);
      // R4 idle high, then R5 falling to idle low
      set_pwm(0, 1, 8'h11); t = cyc;
      exp_ch(t + 1, 0, 8'h00, 1, 0, "R3 lone edge");
      exp_ch(t + 32, 0, 8'h00, 1, 0, "R4 before");
      exp_ch(t + 33, 0, 8'hFF, 1, 1, "R4 high");
      tick(40); set_pwm(0, 0, 8'h11); t = cyc;
      exp_ch(t + 32, 0, 8'hFF, 1, 0, "R5 before");
      exp_ch(t + 33, 0, 8'h00, 1, 1, "R5");
      tick(40);
      // R8 / R9 sleep in transparent mode
      sleep_n = 0; s = cyc;
      exp_ch(s + 1, 0, 8'h00, 0, 0, "R8");
      exp_ch(s + 1, 1, 8'h00, 0, 0, "R8");
      exp_ref(s + 1, 1, "R8");
      tick(4); sleep_n = 1;
      exp_ch(s + 4, 0, 8'h00, 0, 0, "R9 still asleep");
      exp_ch(s + 5, 0, 8'h00, 1, 0, "R9 resume");
      exp_ch(s + 5, 1, 8'h00, 1, 0, "R9 resume");
      exp_ref(s + 5, 0, "R10");
      tick(3);
      // R10 external reference
      ext_ref = 1; exp_ref(cyc, 1, "R10 ext");
      tick(2); ext_ref = 0; tick(1);

      // sample/hold mode
      rst_n = 0; hold_mode = 1; pwm_lvl = '0;
      tick(3); rst_n = 1;
      exp_ch(cyc, 0, 8'h00, 0, 0, "R1 hold");
      exp_ch(cyc, 1, 8'h00, 0, 0, "R1 hold");
      exp_ref(cyc, 1, "R10 none drive");
      tick(2);
      set_pwm(0, 1, 8'h21); b = cyc;
      exp_ch(b + 1, 0, 8'h00, 0, 0, "R7");
      tick(3); set_pwm(0, 0, 8'h21);
      tick(7); set_pwm(0, 1, 8'h77);
      exp_ch(b + 10, 0, 8'h00, 0, 0, "R7 hiz");
      exp_ch(b + 11, 0, 8'h77, 1, 1, "R7");
      exp_ref(b + 11, 0, "R10");
      exp_ch(b + 43, 0, 8'h77, 1, 0, "R6 hold");
      tick(40); set_pwm(0, 0, 8'h77);
      tick(10); set_pwm(0, 1, 8'h12);             // far from previous rise
      exp_ch(b + 61, 0, 8'h77, 1, 0, "R3");
      tick(3); set_pwm(0, 0, 8'h12);
      exp_ch(b + 92, 0, 8'h77, 1, 0, "R6 before");
      exp_ch(b + 93, 0, 8'h77, 0, 0, "R6 off");
      exp_ref(b + 93, 1, "R10");
      tick(35);
      // channel 1 on its own
      set_pwm(1, 1, 8'h5A); k = cyc;
      tick(2); set_pwm(1, 0, 8'h5A);
      tick(6); set_pwm(1, 1, 8'h99);
      exp_ch(k + 9, 1, 8'h99, 1, 1, "R11");
      exp_ch(k + 9, 0, 8'h77, 0, 0, "R11");
      tick(2); set_pwm(1, 0, 8'h99);
      tick(2);
      // sleep in sample/hold mode
      sleep_n = 0; s = cyc;
      exp_ch(s + 1, 1, 8'h99, 0, 0, "R8");
      exp_ref(s + 1, 1, "R8");
      tick(4); sleep_n = 1;
      exp_ch(s + 5, 1, 8'h99, 0, 0, "R9 stays down");
      tick(4); set_pwm(0, 1, 8'h66); w = cyc;
      exp_ch(w + 1, 1, 8'h99, 0, 0, "R9 hiz");
      exp_ch(w + 1, 0, 8'h77, 0, 0, "R9 hiz");
      tick(2); set_pwm(1, 1, 8'h55);
      tick(2); set_pwm(1, 0, 8'h55);
      tick(4); set_pwm(1, 1, 8'h44);
      exp_ch(w + 8, 1, 8'h99, 0, 0, "R9 hiz");
      exp_ch(w + 9, 1, 8'h44, 1, 1, "R9 pair");
      exp_ref(w + 9, 0, "R10");
      tick(5);
      done = 1;
      finish_up();
   end
endmodule